// File: doc/BRIEF.md
# Double-Buffered PWM Pair Generator

This block is one pulse-width generator that drives two output pins from a single up-counter. Software writes a prescaler selection, a period (modulus) and two pulse widths into staging registers. None of these touch the running waveform until software arms a load. Arming copies the staged set into a holding buffer at once. The held set becomes the active set at the next counter wrap, called the reload. The load request then clears itself.

A control register holds three bits: a run enable, the load-arm bit and a reload interrupt enable. All three are usable only while the generator-mode input is high. Each reload that happens while the generator runs sets a sticky reload flag. The interrupt line is that flag gated by the interrupt enable. Two per-pin override inputs can drive a pin to a fixed level whether or not the generator runs. The register port is a plain single-cycle strobe interface with combinational read data and no back-pressure.

Top module: `pwm_pair_gen`

## Requirements
- R1: After reset the control register reads 0x00, both pins and the interrupt line are low, and the staged modulus reads all ones.
- R2: While `gen_mode_i` is low, the control register reads zero, writes to it are ignored, and its run, arm and interrupt-enable bits are cleared.
- R3: Register addresses: 0 control (run bit 7, arm bit 1, interrupt enable bit 0, other bits read 0), 1 status (reload flag bit 0), 2 prescale select bits 1:0 (divide by 1, 2, 4, 8), 3 modulus, 4 width of pin 0, 5 width of pin 1. Staged registers read back their written value.
- R4: A write of one to the arm bit takes effect only if a read of the control register while the arm bit was zero came after the last control write. Otherwise the arm bit stays zero.
- R5: Arming copies the staged settings into the holding buffer. Staged writes made afterwards do not change the pending load.
- R6: Held settings become active only at the next reload, and the arm bit clears itself there.
- R7: Writing zero to the arm bit before the reload cancels the pending load, and the active settings stay unchanged.
- R8: When a control write of one to the arm bit lands on the same cycle as a reload, the written value wins. The load then happens at the following reload, which also clears the arm bit.
- R9: While running, the counter advances once per 2^sel clocks through 0..M-1 for a modulus M. Reload occurs at the wrap. Pin i is high while count < width i. So a width of 0 is always low and a width >= M is always high.
- R10: A pin whose override enable is set drives its override value. Otherwise the pin is low while the generator is stopped.
- R11: The reload flag sets on each reload. Writing one to status bit 0 clears it, and a reload in the same cycle wins.
- R12: The interrupt line is high exactly when the reload flag and the interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gen_mode_i | input | 1 | Generator-mode enable for control register access |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CW | Write data |
| rdata_o | output | CW | Read data (combinational on addr_i) |
| ovr_en_i | input | 2 | Per-pin override enable |
| ovr_val_i | input | 2 | Per-pin override level |
| pwm_o | output | 2 | PWM output pins |
| irq_o | output | 1 | Reload interrupt request |

## Verification
A corrupted active set shows up within one PWM period, as a wrong high-time count on a pin over a full period. A fault in the arm bit shows up differently. If it sticks, the arm bit still reads one after the expected reload. If it clears early, the staged rather than the held value appears in the next period. Both are visible after at most two periods. The coincident-write case is driven on the exact reload cycle, found by polling the reload flag. A wrong priority there leaves the arm bit clear, which shows in the next read.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_PSC  = 3'd2;
  localparam logic [2:0] RA_MOD  = 3'd3;
  localparam logic [2:0] RA_WA   = 3'd4;
  localparam int BIT_RUN  = 7;
  localparam int BIT_LDOK = 1;
  localparam int BIT_RIE  = 0;
  localparam int PSC_W    = 2;
  localparam int NCH      = 2;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pair_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gen_mode,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [2:0]               addr,
  input  logic [CW-1:0]            wdata,
  output logic [CW-1:0]            rdata,
  input  logic                     reload,
  output logic                     run,
  output logic                     rie,
  output logic                     ldok,
  output logic                     flag,
  output logic [PSC_W-1:0]         act_psc,
  output logic [CW-1:0]            act_mod,
  output logic [NCH-1:0][CW-1:0]   act_wid
);
  logic [PSC_W-1:0]       stg_psc, buf_psc;
  logic [CW-1:0]          stg_mod, buf_mod;
  logic [NCH-1:0][CW-1:0] stg_wid, buf_wid;
  logic                   rd_seen, wr_ctrl, ldok_nxt, arm;

  assign wr_ctrl = wr_en && gen_mode && (addr == RA_CTRL);

  always_comb begin
    if (!gen_mode)              ldok_nxt = 1'b0;
    else if (wr_ctrl)           ldok_nxt = wdata[BIT_LDOK] && (ldok || rd_seen);
    else if (reload && ldok)    ldok_nxt = 1'b0;
    else                        ldok_nxt = ldok;
  end
  assign arm = ldok_nxt && !ldok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      rie     <= 1'b0;
      ldok    <= 1'b0;
      rd_seen <= 1'b0;
      flag    <= 1'b0;
      stg_psc <= '0;
      buf_psc <= '0;
      act_psc <= '0;
      stg_mod <= '1;
      buf_mod <= '1;
      act_mod <= '1;
      stg_wid <= '0;
      buf_wid <= '0;
      act_wid <= '0;
    end else begin
      ldok <= ldok_nxt;
      if (!gen_mode) begin
        run <= 1'b0;
        rie <= 1'b0;
      end else if (wr_ctrl) begin
        run <= wdata[BIT_RUN];
        rie <= wdata[BIT_RIE];
      end
      if (!gen_mode || wr_ctrl)                       rd_seen <= 1'b0;
      else if (rd_en && addr == RA_CTRL && !ldok)     rd_seen <= 1'b1;
      if (reload)                                     flag <= 1'b1;
      else if (wr_en && addr == RA_STAT && wdata[0])  flag <= 1'b0;
      if (wr_en && addr == RA_PSC) stg_psc <= wdata[PSC_W-1:0];
      if (wr_en && addr == RA_MOD) stg_mod <= wdata;
      for (int c = 0; c < NCH; c++) begin
        if (wr_en && addr == RA_WA + 3'(c)) stg_wid[c] <= wdata;
      end
      if (arm) begin
        buf_psc <= stg_psc;
        buf_mod <= stg_mod;
        buf_wid <= stg_wid;
      end
      if (reload && ldok) begin
        act_psc <= buf_psc;
        act_mod <= buf_mod;
        act_wid <= buf_wid;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == RA_CTRL) begin
      if (gen_mode) begin
        rdata[BIT_RUN]  = run;
        rdata[BIT_LDOK] = ldok;
        rdata[BIT_RIE]  = rie;
      end
    end else if (addr == RA_STAT) begin
      rdata[0] = flag;
    end else if (addr == RA_PSC) begin
      rdata[PSC_W-1:0] = stg_psc;
    end else if (addr == RA_MOD) begin
      rdata = stg_mod;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (addr == RA_WA + 3'(c)) rdata = stg_wid[c];
      end
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW    = 8,
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [CW-1:0]    modulus,
  output logic [CW-1:0]    cnt,
  output logic             reload
);
  localparam int PC_W = (1 << PSC_W) - 1;

  logic [PC_W-1:0] pc, mask;
  logic            tick, wrap;

  assign mask   = PC_W'((32'd1 << psc) - 32'd1);
  assign tick   = run && (pc == mask);
  assign wrap   = ({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, modulus};
  assign reload = tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      cnt <= '0;
    end else if (!run) begin
      pc  <= '0;
      cnt <= '0;
    end else begin
      pc <= tick ? '0 : pc + PC_W'(1);
      if (tick) cnt <= wrap ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int CW  = 8,
  parameter int NCH = 2
) (
  input  logic                   run,
  input  logic [CW-1:0]          cnt,
  input  logic [NCH-1:0][CW-1:0] wid,
  input  logic [NCH-1:0]         ovr_en,
  input  logic [NCH-1:0]         ovr_val,
  output logic [NCH-1:0]         pins
);
  for (genvar c = 0; c < NCH; c++) begin : g_pin
    assign pins[c] = ovr_en[c] ? ovr_val[c] : (run && (cnt < wid[c]));
  end
endmodule

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen
  import pwm_pair_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gen_mode_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [2:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  input  logic [1:0]    ovr_en_i,
  input  logic [1:0]    ovr_val_i,
  output logic [1:0]    pwm_o,
  output logic          irq_o
);
  logic                   run, rie, ldok, flag, reload;
  logic [PSC_W-1:0]       act_psc;
  logic [CW-1:0]          act_mod, cnt;
  logic [NCH-1:0][CW-1:0] act_wid;

  pwm_regs #(.CW(CW)) u_regs (
    .clk(clk_i), .rst_n(rst_ni), .gen_mode(gen_mode_i),
    .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i), .wdata(wdata_i),
    .rdata(rdata_o), .reload(reload), .run(run), .rie(rie), .ldok(ldok),
    .flag(flag), .act_psc(act_psc), .act_mod(act_mod), .act_wid(act_wid)
  );

  pwm_timebase #(.CW(CW), .PSC_W(PSC_W)) u_tb (
    .clk(clk_i), .rst_n(rst_ni), .run(run), .psc(act_psc),
    .modulus(act_mod), .cnt(cnt), .reload(reload)
  );

  pwm_outstage #(.CW(CW), .NCH(NCH)) u_out (
    .run(run), .cnt(cnt), .wid(act_wid), .ovr_en(ovr_en_i),
    .ovr_val(ovr_val_i), .pins(pwm_o)
  );

  assign irq_o = flag && rie;
endmodule

// File: rtl/pwm_pair_gen_chk.sv
module pwm_pair_gen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gen_mode,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [CW-1:0] wdata,
  input logic          run,
  input logic          ldok,
  input logic          rie,
  input logic          flag,
  input logic          reload,
  input logic          irq,
  input logic [CW-1:0] act_mod,
  input logic [CW-1:0] cnt,
  input logic [1:0]    ovr_en,
  input logic [1:0]    pwm
);
  p_mode_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_mode |=> (!run && !ldok && !rie));
  p_arm_autoclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && ldok && !(wr_en && addr == 3'd0)) |=> !ldok);
  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(act_mod));
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mod != '0) |-> (cnt < act_mod));
  p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ovr_en[0]) |-> !pwm[0]);
  p_reload_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> run);
  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> flag);
  p_flag_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && wr_en && addr == 3'd1 && wdata[0]) |=> !flag);
  p_irq_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (rie && flag));
endmodule

bind pwm_pair_gen pwm_pair_gen_chk #(.CW(CW)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .gen_mode(gen_mode_i), .wr_en(wr_en_i),
  .addr(addr_i), .wdata(wdata_i), .run(run), .ldok(ldok), .rie(rie),
  .flag(flag), .reload(reload), .irq(irq_o), .act_mod(act_mod), .cnt(cnt),
  .ovr_en(ovr_en_i), .pwm(pwm_o)
);

// File: tb/pwm_pair_gen_tb.sv
`timescale 1ns/100ps
module pwm_pair_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gen_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] ovr_en = '0, ovr_val = '0, pwm;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // {prescale select, modulus, width0, width1}
  localparam logic [31:0] VEC [0:4] = '{
    32'h00_0A_03_07, 32'h01_06_00_06, 32'h02_05_09_02,
    32'h03_04_01_03, 32'h00_01_01_00
  };

  pwm_pair_gen #(.CW(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gen_mode_i(gen_mode), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ovr_en_i(ovr_en), .ovr_val_i(ovr_val), .pwm_o(pwm), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_loaded();
    addr = 3'd0; rd_en = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      #1;
      if (rdata[1] == 1'b0) break;
      @(negedge clk);
    end
    rd_en = 1'b0;
  endtask

  task automatic measure(input int n, output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int i = 0; i < n; i++) begin
      h0 += int'(pwm[0]);
      h1 += int'(pwm[1]);
      @(negedge clk);
    end
  endtask

  task automatic load_cfg(input logic [31:0] v);
    logic [7:0] d;
    wr(3'd2, v[31:24]);
    wr(3'd3, v[23:16]);
    wr(3'd4, v[15:8]);
    wr(3'd5, v[7:0]);
    rd(3'd0, d);
    wr(3'd0, 8'h82);
    wait_loaded();
  endtask

  initial begin
    logic [7:0] d;
    int h0, h1, dv, m, e0, e1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, d); chk(d == 8'h00, "R1 ctrl", d, 0);
    chk(pwm == 2'b00 && irq == 1'b0, "R1 pins/irq", {irq, pwm}, 0);
    rd(3'd3, d); chk(d == 8'hFF, "R1 staged modulus", d, 255);
    // R2 mode low: writes ignored, reads zero
    rd(3'd0, d);
    wr(3'd0, 8'h83);
    rd(3'd0, d); chk(d == 8'h00, "R2 read in mode low", d, 0);
    gen_mode = 1'b1;
    rd(3'd0, d); chk(d == 8'h00, "R2 write ignored", d, 0);
    // R3 staged readback
    wr(3'd2, 8'h03); rd(3'd2, d); chk(d == 8'h03, "R3 prescale readback", d, 3);
    wr(3'd5, 8'h5A); rd(3'd5, d); chk(d == 8'h5A, "R3 width1 readback", d, 90);

    // R9 vector walk
    for (int k = 0; k < 5; k++) begin
      load_cfg(VEC[k]);
      dv = 1 << VEC[k][25:24];
      m  = int'(VEC[k][23:16]);
      e0 = (int'(VEC[k][15:8]) >= m ? m : int'(VEC[k][15:8])) * dv;
      e1 = (int'(VEC[k][7:0])  >= m ? m : int'(VEC[k][7:0]))  * dv;
      measure(m * dv, h0, h1);
      chk(h0 == e0, "R9 pin0 high time", h0, e0);
      chk(h1 == e1, "R9 pin1 high time", h1, e1);
    end

    // R7 cancel on a slow period (80 cycles)
    load_cfg(32'h03_0A_03_02);
    wr(3'd4, 8'h07);
    rd(3'd0, d);
    wr(3'd0, 8'h82);
    wr(3'd0, 8'h80);
    rd(3'd0, d); chk(d[1] == 1'b0, "R7 arm cancelled", d[1], 0);
    wait_loaded();
    measure(80, h0, h1);
    chk(h0 == 24, "R7 active width unchanged", h0, 24);
    // R5 snapshot at arm, R6 arm still set before reload
    wr(3'd4, 8'h05);
    rd(3'd0, d);
    wr(3'd0, 8'h82);
    wr(3'd4, 8'h00);
    rd(3'd0, d); chk(d[1] == 1'b1, "R6 arm pending", d[1], 1);
    measure(8, h0, h1);
    chk(h0 == 8, "R6 old width before reload", h0, 8);
    wait_loaded();
    measure(80, h0, h1);
    chk(h0 == 40, "R5 snapshot width used", h0, 40);
    // R4 set without a preceding read
    wr(3'd0, 8'h80);
    wr(3'd0, 8'h82);
    rd(3'd0, d); chk(d[1] == 1'b0, "R4 arm needs read", d[1], 0);

    // R8 coincident arm write on a reload cycle (modulus 4, div 1)
    load_cfg(32'h00_04_01_03);
    wr(3'd4, 8'h03);
    wr(3'd1, 8'h01);
    addr = 3'd1; rd_en = 1'b1;
    for (int i = 0; i < 50; i++) begin
      #1;
      if (rdata[0]) break;
      @(negedge clk);
    end
    addr = 3'd0;            // read of ctrl with arm clear, after reload edge E
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    addr = 3'd0; wdata = 8'h82; wr_en = 1'b1;   // captured at E+4
    @(negedge clk); wr_en = 1'b0;
    rd(3'd0, d); chk(d[1] == 1'b1, "R8 written arm wins", d[1], 1);
    repeat (3) @(negedge clk);
    rd(3'd0, d); chk(d[1] == 1'b0, "R8 cleared at following reload", d[1], 0);
    measure(4, h0, h1);
    chk(h0 == 3, "R8 load at following reload", h0, 3);

    // R11/R12 flag and interrupt
    rd(3'd1, d); chk(d[0] == 1'b1, "R11 flag set by reload", d[0], 1);
    chk(irq == 1'b0, "R12 irq gated off", irq, 0);
    wr(3'd0, 8'h81);
    chk(irq == 1'b1, "R12 irq enabled", irq, 1);
    wr(3'd0, 8'h01);
    repeat (2) @(negedge clk);
    rd(3'd1, d); chk(d[0] == 1'b1, "R11 flag sticky when stopped", d[0], 1);
    wr(3'd1, 8'h01);
    rd(3'd1, d); chk(d[0] == 1'b0 && irq == 1'b0, "R11 flag cleared", {irq, d[0]}, 0);
    // R10 stopped pins and override
    measure(8, h0, h1);
    chk(h0 == 0 && h1 == 0, "R10 stopped pins low", h0 + h1, 0);
    ovr_en = 2'b11; ovr_val = 2'b10;
    #1 chk(pwm == 2'b10, "R10 override drives value", pwm, 2);
    ovr_en = 2'b00;
    // R2 dropping mode clears bits
    @(negedge clk);
    wr(3'd0, 8'h81);
    gen_mode = 1'b0;
    @(negedge clk);
    gen_mode = 1'b1;
    rd(3'd0, d); chk(d == 8'h00, "R2 bits cleared by mode low", d, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule